// File: doc/BRIEF.md
# Queued SPI Status Flag Register

This unit holds the sticky status flags of a queued SPI controller. The shift engine, the two FIFOs and the command sequencer report events as one-cycle strobes or levels. The unit turns them into six flags: frame done, running, queue finished, transmit starved, transmit room and receive overrun. Software reads all six as one 32-bit status word and clears any of them by writing a 1 to its bit. The transmit room flag can also be retired by a DMA acknowledge. A bus decoder outside the unit supplies a write strobe when this register is addressed.

The flags affect each other, and each depends on the controller role. When the queue finished flag sets, the run flag drops. The queue finished flag never sets while the controller is a slave. The transmit starved flag only sets when the controller is a slave using SPI framing. A masked OR of the flags drives an interrupt request, and the transmit room flag drives a DMA request when DMA is enabled. Every flag takes its new value one clock after the event that sets it. The read word and the request outputs follow the registered flags with no further delay.

Top module: `spiq_status_unit`

## Requirements
- R1: After reset all flags read 0 except transmit room, which reads 1. The status word is then 32'h0200_0000.
- R2: Fields use MSB-first numbering, so field n sits at rd_data[31-n]. Frame done is field 0 (rd_data[31]), running is field 1 ([30]), queue finished is field 3 ([28]), transmit starved is field 4 ([27]), transmit room is field 6 ([25]) and receive overrun is field 12 ([19]). All other bits read 0.
- R3: Frame done sets on the cycle after ev_last_bit is high. It stays set until a write with wr_data[31]=1 clears it.
- R4: Running sets after ev_run_start and is cleared by writing 1 to rd_data[30]. In a cycle where queue finished is being set, running goes to 0, even if ev_run_start is also high.
- R5: Queue finished sets after a cycle with ev_last_bit, ev_cmd_eoq and mode_master all high. It never sets while mode_master is 0. Writing 1 to bit [28] clears it.
- R6: Transmit starved sets after a cycle in which mode_master=0, cfg_spi_fmt=1, ev_xfer_start=1 and txf_empty=1. Writing 1 to bit [27] clears it.
- R7: Transmit room is set every cycle after one with txf_full=0. A write of 1 to bit [25], or dma_ack, clears it only while txf_full=1.
- R8: Receive overrun sets after a cycle in which ev_xfer_start, rxf_full and rx_shift_full are all high. Writing 1 to bit [19] clears it.
- R9: If a flag's set condition and a write-1 clear of that flag occur in the same cycle, the flag ends up set.
- R10: Writing 0 to a flag bit leaves it unchanged. Writing to a reserved bit has no effect. With wr_en low, wr_data has no effect.
- R11: irq_req is the OR over i of flag[i] AND irq_en[i], using index 0 frame done, 1 running, 2 queue finished, 3 transmit starved, 4 transmit room, 5 receive overrun.
- R12: dma_req is high exactly when transmit room is set and dma_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1 = controller is master, 0 = slave |
| cfg_spi_fmt | input | 1 | 1 = SPI framing selected |
| ev_last_bit | input | 1 | Last incoming bit of a frame sampled |
| ev_cmd_eoq | input | 1 | Executing command entry marks end of queue |
| ev_run_start | input | 1 | Sequencer enters the running state |
| ev_xfer_start | input | 1 | A frame transfer is starting |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_full | input | 1 | Transmit FIFO full |
| rxf_full | input | 1 | Receive FIFO full |
| rx_shift_full | input | 1 | Receive shift register holds an unread frame |
| dma_ack | input | 1 | DMA acknowledge for transmit room |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 32 | Write data, a 1 clears the flag at that bit |
| rd_data | output | 32 | Status word |
| irq_en | input | 6 | Per-flag interrupt enables |
| dma_en | input | 1 | DMA request enable for transmit room |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bound checker tests these properties on every cycle:
- reserved bits read zero;
- frame done, transmit room and receive overrun set after their events;
- queue finished cannot rise in slave mode;
- running is forced low when queue finished sets;
- a write-1 clear with no competing set takes effect;
- dma_req is low whenever DMA is disabled.

Some behaviours need a model of all flags across a sequence, so only the bench scenarios show them. These are the reset word, set winning over a same-cycle clear, the DMA acknowledge being ignored while the FIFO has room, writes of zero or to reserved bits leaving the word unchanged, and the interrupt OR under changing enable masks.

// File: rtl/spiq_stat_pkg.sv
package spiq_stat_pkg;

    localparam int FLAG_N = 6;

    typedef enum int {
        FLG_DONE  = 0,
        FLG_RUN   = 1,
        FLG_QEND  = 2,
        FLG_STARV = 3,
        FLG_ROOM  = 4,
        FLG_OVRN  = 5
    } flag_idx_e;

    // Field number of each flag, counted from the most significant bit.
    function automatic int msbf_field(int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 3;
            3:       return 4;
            4:       return 6;
            default: return 12;
        endcase
    endfunction

    // Reset value of each flag: only the transmit room flag starts set.
    localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1) << FLG_ROOM;

    typedef struct packed {
        logic [FLAG_N-1:0] set;
        logic [FLAG_N-1:0] kill;
    } flag_evt_t;

    typedef struct packed {
        logic [FLAG_N-1:0] flags;
    } flag_state_t;

endpackage

// File: rtl/spiq_event_qual.sv
module spiq_event_qual
    import spiq_stat_pkg::*;
(
    input  logic      mode_master,
    input  logic      cfg_spi_fmt,
    input  logic      ev_last_bit,
    input  logic      ev_cmd_eoq,
    input  logic      ev_run_start,
    input  logic      ev_xfer_start,
    input  logic      txf_empty,
    input  logic      txf_full,
    input  logic      rxf_full,
    input  logic      rx_shift_full,
    output flag_evt_t evt
);

    always_comb begin
        evt = '0;
        evt.set[FLG_DONE]  = ev_last_bit;
        evt.set[FLG_QEND]  = ev_last_bit & ev_cmd_eoq & mode_master;
        evt.set[FLG_RUN]   = ev_run_start;
        evt.set[FLG_STARV] = ~mode_master & cfg_spi_fmt & ev_xfer_start & txf_empty;
        evt.set[FLG_ROOM]  = ~txf_full;
        evt.set[FLG_OVRN]  = ev_xfer_start & rxf_full & rx_shift_full;
        // Queue end stops the run state with priority over a new start.
        evt.kill[FLG_RUN]  = evt.set[FLG_QEND];
    end

endmodule

// File: rtl/spiq_flag_bank.sv
module spiq_flag_bank
    import spiq_stat_pkg::*;
#(
    parameter logic [FLAG_N-1:0] RST_VAL = FLAG_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flag_evt_t         evt,
    input  logic [FLAG_N-1:0] clr,
    output logic [FLAG_N-1:0] flags
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < FLAG_N; i++) begin
            st_d.flags[i] = (evt.set[i] | (st_q.flags[i] & ~clr[i])) & ~evt.kill[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/spiq_req_out.sv
module spiq_req_out
    import spiq_stat_pkg::*;
(
    input  logic [FLAG_N-1:0] flags,
    input  logic [FLAG_N-1:0] irq_en,
    input  logic              dma_en,
    output logic              irq_req,
    output logic              dma_req
);

    always_comb begin
        irq_req = |(flags & irq_en);
        dma_req = flags[FLG_ROOM] & dma_en;
    end

endmodule

// File: rtl/spiq_status_unit.sv
module spiq_status_unit
    import spiq_stat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              cfg_spi_fmt,
    input  logic              ev_last_bit,
    input  logic              ev_cmd_eoq,
    input  logic              ev_run_start,
    input  logic              ev_xfer_start,
    input  logic              txf_empty,
    input  logic              txf_full,
    input  logic              rxf_full,
    input  logic              rx_shift_full,
    input  logic              dma_ack,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FLAG_N-1:0] irq_en,
    input  logic              dma_en,
    output logic              irq_req,
    output logic              dma_req
);

    flag_evt_t         evt;
    logic [FLAG_N-1:0] wr_hit;
    logic [FLAG_N-1:0] clr;
    logic [FLAG_N-1:0] flags;
    logic [DATA_W-1:0] fld_mask;

    generate
        for (genvar g = 0; g < FLAG_N; g++) begin : g_map
            localparam int POS = DATA_W - 1 - msbf_field(g);
            assign wr_hit[g]     = wr_en & wr_data[POS];
            assign rd_data[POS]  = flags[g];
        end
    endgenerate

    always_comb begin
        fld_mask = '0;
        for (int i = 0; i < FLAG_N; i++) begin
            fld_mask[DATA_W-1-msbf_field(i)] = 1'b1;
        end
    end

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_rsv
            if (!((b == DATA_W-1-msbf_field(0)) || (b == DATA_W-1-msbf_field(1)) ||
                  (b == DATA_W-1-msbf_field(2)) || (b == DATA_W-1-msbf_field(3)) ||
                  (b == DATA_W-1-msbf_field(4)) || (b == DATA_W-1-msbf_field(5)))) begin : g_zero
                assign rd_data[b] = 1'b0;
            end
        end
    endgenerate

    logic unused_wr_bits;
    assign unused_wr_bits = ^(wr_data & ~fld_mask);

    // Software clears; the DMA acknowledge only retires transmit room while full.
    always_comb begin
        clr = wr_hit;
        clr[FLG_ROOM] = wr_hit[FLG_ROOM] | (dma_ack & txf_full);
    end

    spiq_event_qual u_qual (
        .mode_master   (mode_master),
        .cfg_spi_fmt   (cfg_spi_fmt),
        .ev_last_bit   (ev_last_bit),
        .ev_cmd_eoq    (ev_cmd_eoq),
        .ev_run_start  (ev_run_start),
        .ev_xfer_start (ev_xfer_start),
        .txf_empty     (txf_empty),
        .txf_full      (txf_full),
        .rxf_full      (rxf_full),
        .rx_shift_full (rx_shift_full),
        .evt           (evt)
    );

    spiq_flag_bank #(.RST_VAL(FLAG_RST)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr),
        .flags (flags)
    );

    spiq_req_out u_req (
        .flags   (flags),
        .irq_en  (irq_en),
        .dma_en  (dma_en),
        .irq_req (irq_req),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/spiq_status_chk.sv
module spiq_status_chk
    import spiq_stat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_master,
    input logic              ev_last_bit,
    input logic              ev_cmd_eoq,
    input logic              ev_xfer_start,
    input logic              txf_full,
    input logic              rxf_full,
    input logic              rx_shift_full,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              dma_en,
    input logic              dma_req
);

    localparam int P_DONE = DATA_W - 1 - msbf_field(0);
    localparam int P_RUN  = DATA_W - 1 - msbf_field(1);
    localparam int P_QEND = DATA_W - 1 - msbf_field(2);
    localparam int P_ROOM = DATA_W - 1 - msbf_field(4);
    localparam int P_OVRN = DATA_W - 1 - msbf_field(5);

    logic [DATA_W-1:0] fmask;
    always_comb begin
        fmask = '0;
        for (int i = 0; i < FLAG_N; i++) fmask[DATA_W-1-msbf_field(i)] = 1'b1;
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~fmask) == '0);

    assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_last_bit |=> rd_data[P_DONE]);

    assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[P_DONE] && !ev_last_bit) |=> !rd_data[P_DONE]);

    assert_qend_stops_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_last_bit && ev_cmd_eoq && mode_master) |=> (!rd_data[P_RUN] && rd_data[P_QEND]));

    assert_qend_not_in_slave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !rd_data[P_QEND]) |=> !rd_data[P_QEND]);

    assert_room_when_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !txf_full |=> rd_data[P_ROOM]);

    assert_ovrn_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_xfer_start && rxf_full && rx_shift_full) |=> rd_data[P_OVRN]);

    assert_dma_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

endmodule

bind spiq_status_unit spiq_status_chk #(.DATA_W(DATA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_master   (mode_master),
    .ev_last_bit   (ev_last_bit),
    .ev_cmd_eoq    (ev_cmd_eoq),
    .ev_xfer_start (ev_xfer_start),
    .txf_full      (txf_full),
    .rxf_full      (rxf_full),
    .rx_shift_full (rx_shift_full),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .dma_en        (dma_en),
    .dma_req       (dma_req)
);

// File: tb/spiq_status_unit_tb_top.sv
module spiq_status_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_master = 0, cfg_spi_fmt = 0, ev_last_bit = 0, ev_cmd_eoq = 0;
    logic        ev_run_start = 0, ev_xfer_start = 0, txf_empty = 0, txf_full = 0;
    logic        rxf_full = 0, rx_shift_full = 0, dma_ack = 0, wr_en = 0, dma_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  irq_en = '0;
    logic        irq_req, dma_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Bench model: index 0 done,1 run,2 qend,3 starv,4 room,5 ovrn
    logic [5:0] m;
    logic [31:0] rng1 = 32'h1234_5678;
    logic [31:0] rng2 = 32'h9abc_def1;

    always #5 clk = ~clk;

    spiq_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .cfg_spi_fmt(cfg_spi_fmt),
        .ev_last_bit(ev_last_bit), .ev_cmd_eoq(ev_cmd_eoq), .ev_run_start(ev_run_start),
        .ev_xfer_start(ev_xfer_start), .txf_empty(txf_empty), .txf_full(txf_full),
        .rxf_full(rxf_full), .rx_shift_full(rx_shift_full), .dma_ack(dma_ack),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_en(irq_en),
        .dma_en(dma_en), .irq_req(irq_req), .dma_req(dma_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [5:0] f);
        logic [31:0] w = '0;
        w[31] = f[0]; w[30] = f[1]; w[28] = f[2];
        w[27] = f[3]; w[25] = f[4]; w[19] = f[5];
        return w;
    endfunction

    task automatic compare_all();
        logic [31:0] e = word_of(m);
        check(rd_data[31] == e[31], "R3 done",  rd_data, e);
        check(rd_data[30] == e[30], "R4 run",   rd_data, e);
        check(rd_data[28] == e[28], "R5 qend",  rd_data, e);
        check(rd_data[27] == e[27], "R6 starv", rd_data, e);
        check(rd_data[25] == e[25], "R7 room",  rd_data, e);
        check(rd_data[19] == e[19], "R8 ovrn",  rd_data, e);
        check((rd_data & 32'h25F7_FFFF) == 0, "R2 reserved", rd_data, 32'h0);
        check(irq_req == |(m & irq_en), "R11 irq", {31'b0, irq_req}, {31'b0, |(m & irq_en)});
        check(dma_req == (m[4] & dma_en), "R12 dma", {31'b0, dma_req}, {31'b0, m[4] & dma_en});
    endtask

    // Inputs are already driven; advance one edge and update model.
    task automatic step();
        logic [5:0] hit;
        logic       qset;
        @(posedge clk);
        hit  = {wr_data[19], wr_data[25], wr_data[27], wr_data[28], wr_data[30], wr_data[31]} & {6{wr_en}};
        qset = ev_last_bit & ev_cmd_eoq & mode_master;
        m[0] = ev_last_bit | (m[0] & ~hit[0]);
        m[1] = qset ? 1'b0 : (ev_run_start | (m[1] & ~hit[1]));
        m[2] = qset | (m[2] & ~hit[2]);
        m[3] = (~mode_master & cfg_spi_fmt & ev_xfer_start & txf_empty) | (m[3] & ~hit[3]);
        m[4] = ~txf_full | (m[4] & ~hit[4] & ~(dma_ack & txf_full));
        m[5] = (ev_xfer_start & rxf_full & rx_shift_full) | (m[5] & ~hit[5]);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        ev_last_bit = 0; ev_cmd_eoq = 0; ev_run_start = 0; ev_xfer_start = 0;
        txf_empty = 0; txf_full = 1; rxf_full = 0; rx_shift_full = 0;
        dma_ack = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        m = 6'b010000;
        idle();
        mode_master = 1; cfg_spi_fmt = 1;
        repeat (3) @(negedge clk);
        // R1: reset word and request outputs
        check(rd_data == 32'h0200_0000, "R1 reset word", rd_data, 32'h0200_0000);
        irq_en = 6'b010000; dma_en = 1; #1;
        check(irq_req == 1'b1, "R1 R11 irq from room", {31'b0, irq_req}, 32'h1);
        check(dma_req == 1'b1, "R1 R12 dma from room", {31'b0, dma_req}, 32'h1);
        irq_en = 6'b101111; #1;
        check(irq_req == 1'b0, "R11 masked", {31'b0, irq_req}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R7: dma_ack while not full is ignored, while full clears
        idle(); txf_full = 0; dma_ack = 1; step();
        check(rd_data[25] == 1'b1, "R7 ack ignored with room", rd_data, 32'h0200_0000);
        idle(); dma_ack = 1; step();
        check(rd_data[25] == 1'b0, "R7 ack clears when full", rd_data, 32'h0);

        // R9: set beats same-cycle write-1 clear
        idle(); ev_last_bit = 1; wr_en = 1; wr_data = 32'h8000_0000; step();
        check(rd_data[31] == 1'b1, "R9 set wins", rd_data, 32'h8000_0000);

        // R4: queue end beats a same-cycle run start
        idle(); ev_run_start = 1; step();
        idle(); ev_run_start = 1; ev_last_bit = 1; ev_cmd_eoq = 1; step();
        check(rd_data[30] == 1'b0 && rd_data[28] == 1'b1, "R4 qend stops run", rd_data, 32'h9000_0000);

        // R5: slave mode never sets queue end
        idle(); wr_en = 1; wr_data = 32'h1000_0000; step();
        idle(); mode_master = 0; ev_last_bit = 1; ev_cmd_eoq = 1; step();
        check(rd_data[28] == 1'b0, "R5 slave no qend", rd_data, 32'h8000_0000);

        // R6 and R8: starvation and overrun set
        idle(); ev_xfer_start = 1; txf_empty = 1; rxf_full = 1; rx_shift_full = 1; step();
        check(rd_data[27] == 1'b1 && rd_data[19] == 1'b1, "R6 R8 set", rd_data, 32'h8808_0000);

        // R10: zero writes, reserved writes and unstrobed writes change nothing
        idle(); wr_en = 1; wr_data = 32'h0; step();
        check(rd_data == word_of(m), "R10 zero write", rd_data, word_of(m));
        idle(); wr_en = 1; wr_data = 32'h25F7_FFFF; step();
        check(rd_data == 32'h8808_0000, "R10 reserved write", rd_data, 32'h8808_0000);
        idle(); wr_en = 0; wr_data = 32'hFFFF_FFFF; step();
        check(rd_data == 32'h8808_0000, "R10 no strobe", rd_data, 32'h8808_0000);
        idle(); wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
        check(rd_data == 32'h0, "R3 R6 R8 all cleared", rd_data, 32'h0);
        mode_master = 1;

        // Broad sweep with pseudo-random stimulus against the model
        for (int i = 0; i < 4000; i++) begin
            rng1 = rng1 ^ (rng1 << 13); rng1 = rng1 ^ (rng1 >> 17); rng1 = rng1 ^ (rng1 << 5);
            rng2 = rng2 ^ (rng2 << 13); rng2 = rng2 ^ (rng2 >> 17); rng2 = rng2 ^ (rng2 << 5);
            mode_master   = rng1[0];
            cfg_spi_fmt   = rng1[1] | rng1[2];
            ev_last_bit   = rng1[3] & rng1[4];
            ev_cmd_eoq    = rng1[5];
            ev_run_start  = rng1[6] & rng1[7];
            ev_xfer_start = rng1[8] & rng1[9];
            txf_empty     = rng1[10];
            txf_full      = rng1[11] | rng1[12];
            rxf_full      = rng1[13];
            rx_shift_full = rng1[14];
            dma_ack       = rng1[15];
            wr_en         = rng1[16] & rng1[17];
            irq_en        = rng1[23:18];
            dma_en        = rng1[24];
            wr_data       = rng2;
            step();
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule